// File: doc/BRIEF.md
# Sync Period and Presence Meter

This block times the horizontal and vertical sync signals that arrive at a display input, so that firmware can work out the video mode. It also reports whether each sync is alive, which is what a display power-management policy needs. Each channel has a source multiplexer, a synchronizer with a rising-edge detector, and a saturating period counter. The counter advances only on a reference tick supplied from outside. The horizontal tick is meant to run at 12 MHz and the vertical tick at 125 kHz, and each count is 12 bits wide.

The horizontal channel takes either the separate sync pin or the output of a sync-on-green slicer. The vertical channel takes either the separate vertical pin or a vertical sync that has already been separated inside the chip. Every rising sync edge stores the running count in a result register and restarts the counter. The result registers and presence flags are plain level outputs, so software can read them at any moment. The block has no streaming data path, so no valid/ready handshake applies. The inputs are assumed to have positive polarity.

Top module: `sync_meter`

## Requirements
- R1: With `h_sel`=0 the horizontal channel measures `hsync_sep`; with `h_sel`=1 it measures `hsync_sog`. The source that is not selected has no effect on `h_period` or `h_present`.
- R2: With `v_sel`=0 the vertical channel measures `vsync_sep`; with `v_sel`=1 it measures `vsync_int`. The source that is not selected has no effect on `v_period` or `v_present`.
- R3: Each input passes through two synchronizing flops before its rising edge is detected. Only rising edges restart the count. On every detected edge, the counter value is stored in the result register and the counter returns to 0. The cycle of the edge itself is not counted. With the tick high every clock, a sync whose period is P clocks reads back P-1.
- R4: A counter advances by one only in a clock cycle where its own tick input is high. With the tick held low, every edge captures 0.
- R5: A counter stops at 4095, the all-ones value of 12 bits. Once it holds 4095, the presence flag of that channel is cleared. An edge that arrives while the counter holds 4095 captures 4095.
- R6: A presence flag is set only on an edge that follows an earlier edge with no saturation of the counter in between. The first edge after reset or after saturation never sets it.
- R7: After reset, both result registers read 0 and both presence flags read 0.
- R8: A result register changes only on a detected edge of its own channel. Otherwise it holds its value, including through saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_tick | input | 1 | Horizontal reference tick enable (12 MHz rate) |
| v_tick | input | 1 | Vertical reference tick enable (125 kHz rate) |
| h_sel | input | 1 | Horizontal source: 0 separate pin, 1 sync-on-green |
| v_sel | input | 1 | Vertical source: 0 separate pin, 1 internally separated |
| hsync_sep | input | 1 | Separate horizontal sync input |
| hsync_sog | input | 1 | Sync-on-green slicer output |
| vsync_sep | input | 1 | Separate vertical sync input |
| vsync_int | input | 1 | Internally separated vertical sync |
| h_period | output | 12 | Last captured horizontal period in ticks |
| h_present | output | 1 | Horizontal sync present |
| v_period | output | 12 | Last captured vertical period in ticks |
| v_present | output | 1 | Vertical sync present |

## Verification
The hardest states to reach from the ports sit at the edge of saturation. One is a period that just escapes the limit, another is one that just hits it, and a third is the first edge after the counter has saturated. To reach them, the bench holds the tick high every clock and drives sync periods of exactly 4095 and 4096 clocks, which read back as 4094 with presence and 4095 without it. It also silences a source for longer than 4095 clocks and then restarts it. The bench then checks that the first new edge captures 4095 and leaves the flag clear, and that the second edge sets it.

// File: rtl/sync_meter_pkg.sv
package sync_meter_pkg;
  // Source choice for either channel
  typedef enum logic {
    SRC_DIRECT = 1'b0,
    SRC_ALT    = 1'b1
  } src_sel_e;

  // Saturation value for a counter of the given width
  function automatic int unsigned sat_value(input int unsigned width);
    return (1 << width) - 1;
  endfunction
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic src_direct,
  input  logic src_alt,
  output logic rise
);
  import sync_meter_pkg::*;

  localparam int CHAIN = STAGES + 1;

  logic             picked;
  logic [CHAIN-1:0] chain_q;

  // Source multiplexer ahead of the synchronizer
  always_comb begin
    if (src_sel_e'(sel) == SRC_ALT) picked = src_alt;
    else                            picked = src_direct;
  end

  // chain_q[0] is the first flop; chain_q[STAGES] is the history flop
  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= picked;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rise,
  output logic [CW-1:0] period,
  output logic          present,
  output logic [CW-1:0] cnt_o
);
  import sync_meter_pkg::*;

  localparam logic [CW-1:0] CNT_MAX = CW'(sat_value(CW));

  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          at_max;

  assign at_max = (cnt_q == CNT_MAX);

  // Free-running tick counter, restarted by every edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (rise)            cnt_q <= '0;
    else if (tick && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  // Result register: loaded only on an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    period <= '0;
    else if (rise) period <= cnt_q;
  end

  // Presence tracking: an edge arms, a second clean edge confirms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      present <= 1'b0;
    end else if (rise) begin
      seen_q  <= 1'b1;
      present <= seen_q && !at_max;
    end else if (at_max) begin
      seen_q  <= 1'b0;
      present <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sync_meter.sv
module sync_meter #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_tick,
  input  logic             v_tick,
  input  logic             h_sel,
  input  logic             v_sel,
  input  logic             hsync_sep,
  input  logic             hsync_sog,
  input  logic             vsync_sep,
  input  logic             vsync_int,
  output logic [CNT_W-1:0] h_period,
  output logic             h_present,
  output logic [CNT_W-1:0] v_period,
  output logic             v_present
);
  logic             h_rise;
  logic             v_rise;
  logic [CNT_W-1:0] h_cnt;
  logic [CNT_W-1:0] v_cnt;

  sync_edge_det #(.STAGES(SYNC_STAGES)) u_hsrc (
    .clk(clk), .rst_n(rst_n), .sel(h_sel),
    .src_direct(hsync_sep), .src_alt(hsync_sog), .rise(h_rise)
  );

  sync_edge_det #(.STAGES(SYNC_STAGES)) u_vsrc (
    .clk(clk), .rst_n(rst_n), .sel(v_sel),
    .src_direct(vsync_sep), .src_alt(vsync_int), .rise(v_rise)
  );

  period_meter #(.CW(CNT_W)) u_hmeas (
    .clk(clk), .rst_n(rst_n), .tick(h_tick), .rise(h_rise),
    .period(h_period), .present(h_present), .cnt_o(h_cnt)
  );

  period_meter #(.CW(CNT_W)) u_vmeas (
    .clk(clk), .rst_n(rst_n), .tick(v_tick), .rise(v_rise),
    .period(v_period), .present(v_present), .cnt_o(v_cnt)
  );
endmodule

// File: rtl/sync_meter_chk.sv
module sync_meter_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_tick,
  input logic          v_tick,
  input logic          h_rise,
  input logic          v_rise,
  input logic [CW-1:0] h_cnt,
  input logic [CW-1:0] v_cnt,
  input logic [CW-1:0] h_period,
  input logic [CW-1:0] v_period,
  input logic          h_present,
  input logic          v_present
);
  localparam logic [CW-1:0] TOP = '1;

  // R3
  h_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_rise |=> (h_cnt == '0));
  // R3
  v_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_rise |=> (v_cnt == '0));
  // R4
  h_tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_rise && !h_tick) |=> $stable(h_cnt));
  // R4
  v_tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_rise && !v_tick) |=> $stable(v_cnt));
  // R5
  h_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == TOP && !h_rise) |=> (h_cnt == TOP && !h_present));
  // R5
  v_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_cnt == TOP && !v_rise) |=> (v_cnt == TOP && !v_present));
  // R6
  h_present_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_present) |-> $past(h_rise));
  // R6
  v_present_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_present) |-> $past(v_rise));
  // R8
  h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rise |=> $stable(h_period));
  // R8
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_rise |=> $stable(v_period));
endmodule

bind sync_meter sync_meter_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_tick(h_tick), .v_tick(v_tick),
  .h_rise(h_rise), .v_rise(v_rise), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .h_period(h_period), .v_period(v_period),
  .h_present(h_present), .v_present(v_present)
);

// File: tb/sync_meter_tb.sv
module sync_meter_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic h_tick, v_tick, h_sel, v_sel;
  logic hsync_sep, hsync_sog, vsync_sep, vsync_int;
  logic [11:0] h_period, v_period;
  logic h_present, v_present;

  int p_hsep = 0, p_hsog = 0, p_vsep = 0, p_vint = 0;
  int h_div = 1, v_div = 1;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sync_meter u_dut (
    .clk(clk), .rst_n(rst_n), .h_tick(h_tick), .v_tick(v_tick),
    .h_sel(h_sel), .v_sel(v_sel),
    .hsync_sep(hsync_sep), .hsync_sog(hsync_sog),
    .vsync_sep(vsync_sep), .vsync_int(vsync_int),
    .h_period(h_period), .h_present(h_present),
    .v_period(v_period), .v_present(v_present)
  );

  // Pulse generators: period in clocks, high for two clocks; below 3 means silent
  task automatic gen(ref logic s, ref int per);
    forever begin
      if (per < 3) begin
        s = 1'b0;
        @(negedge clk);
      end else begin
        s = 1'b1;
        repeat (2) @(negedge clk);
        s = 1'b0;
        repeat (per - 2) @(negedge clk);
      end
    end
  endtask

  initial gen(hsync_sep, p_hsep);
  initial gen(hsync_sog, p_hsog);
  initial gen(vsync_sep, p_vsep);
  initial gen(vsync_int, p_vint);

  // Tick generator: div 0 means tick never asserted
  initial begin
    int c;
    c = 0;
    h_tick = 1'b0;
    v_tick = 1'b0;
    forever begin
      @(negedge clk);
      c++;
      h_tick = (h_div != 0) && ((c % h_div) == 0);
      v_tick = (v_div != 0) && ((c % v_div) == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Columns: h_sel, v_sel, hsync_sep period, hsync_sog period, vsync_sep period, vsync_int period
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{0, 0, 100,  37, 250,  90},
    '{1, 0, 100,  37, 250,  90},
    '{1, 1, 100,  37, 250,  90},
    '{0, 1,  64, 150, 120, 300},
    '{1, 1,  64, 150, 120, 300},
    '{0, 0,   3,   9,   7,   5}
  };

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp_h, exp_v;
    rst_n = 1'b0;
    h_sel = 1'b0;
    v_sel = 1'b0;
    wait_cyc(4);
    // R7 reset state
    chk(h_period == 0, "R7 h_period", h_period, 0);
    chk(v_period == 0, "R7 v_period", v_period, 0);
    chk(h_present == 0, "R7 h_present", h_present, 0);
    chk(v_present == 0, "R7 v_present", v_present, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R6: vector table, ticks every clock
    for (int i = 0; i < NV; i++) begin
      h_sel  = VEC[i][0][0];
      v_sel  = VEC[i][1][0];
      p_hsep = VEC[i][2];
      p_hsog = VEC[i][3];
      p_vsep = VEC[i][4];
      p_vint = VEC[i][5];
      wait_cyc(1300);
      exp_h = (h_sel ? p_hsog : p_hsep) - 1;
      exp_v = (v_sel ? p_vint : p_vsep) - 1;
      chk(h_period == exp_h, "R1 R3 h_period", h_period, exp_h);
      chk(v_period == exp_v, "R2 R3 v_period", v_period, exp_v);
      chk(h_present == 1, "R6 h_present", h_present, 1);
      chk(v_present == 1, "R6 v_present", v_present, 1);
    end

    // R1: silencing the unselected horizontal source changes nothing
    h_sel  = 1'b0;
    p_hsep = 80;
    p_hsog = 0;
    wait_cyc(600);
    chk(h_period == 79, "R1 unselected silent", h_period, 79);
    chk(h_present == 1, "R1 unselected silent present", h_present, 1);

    // R2: silencing the unselected vertical source changes nothing
    v_sel  = 1'b1;
    p_vint = 60;
    p_vsep = 0;
    wait_cyc(600);
    chk(v_period == 59, "R2 unselected silent", v_period, 59);
    chk(v_present == 1, "R2 unselected silent present", v_present, 1);

    // R4: horizontal tick every other clock, period 40 clocks gives 19 or 20
    h_div  = 2;
    p_hsep = 40;
    wait_cyc(400);
    chk(h_period == 19 || h_period == 20, "R4 halved tick", h_period, 20);

    // R4: vertical tick held low captures 0
    v_div = 0;
    wait_cyc(400);
    chk(v_period == 0, "R4 no tick", v_period, 0);
    chk(v_present == 1, "R4 no tick present", v_present, 1);
    v_div = 1;
    h_div = 1;
    wait_cyc(400);
    chk(h_period == 39, "R3 h period 40", h_period, 39);

    // R5 R8: silence horizontal long enough to saturate
    p_hsep = 0;
    wait_cyc(4400);
    chk(h_present == 0, "R5 h saturation clears present", h_present, 0);
    chk(h_period == 39, "R8 h_period held through saturation", h_period, 39);

    // R5 R6: first edge after saturation captures 4095, flag stays low
    p_hsep = 50;
    wait_cyc(20);
    chk(h_period == 4095, "R5 edge at saturation", h_period, 4095);
    chk(h_present == 0, "R6 first edge no present", h_present, 0);
    wait_cyc(60);
    chk(h_period == 49, "R6 second edge period", h_period, 49);
    chk(h_present == 1, "R6 second edge present", h_present, 1);

    // R5 boundary: 4095 clocks just escapes saturation
    v_sel  = 1'b0;
    p_vsep = 4095;
    wait_cyc(3 * 4095 + 200);
    chk(v_period == 4094, "R5 period 4095", v_period, 4094);
    chk(v_present == 1, "R5 period 4095 present", v_present, 1);

    // R5 boundary: 4096 clocks hits saturation every line
    p_vsep = 4096;
    wait_cyc(4 * 4096 + 200);
    chk(v_period == 4095, "R5 period 4096", v_period, 4095);
    chk(v_present == 0, "R5 period 4096 present", v_present, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule